// File: doc/BRIEF.md
# Indirect Register File Access Port

This block connects an 8-bit processor bus to a 64-location internal register file. The processor does not see the register file directly. It sees a small window instead: a 6-bit location pointer, a byte that holds write data, and a byte that holds read data. The block synchronises the bus strobes into its own clock domain. It turns completed bus cycles into pointer loads, single-cycle register file writes and reloads of the read-data byte.

Static mode pins select how the bus is decoded.

- **Direct mode:** a select line picks either the pointer or the data window.
- **Multiplexed mode:** an address-latch strobe captures the pointer from the shared data lines, and the following read or write strobe moves the data.
- **Other mode codes:** the block ignores the bus completely.

The pointer never advances by itself. A run of reads or writes without a new address therefore keeps hitting the same location.

Top module: `regfile_access_port`

## Requirements
- R1: After reset the pointer (`rf_addr_o`) is 0, the held write byte (`rf_wdata_o`) is 0, `rf_we_o` is low and the data bus is not driven (`data_oe_o` = 0).
- R2: With `mode_i` = 2'b00, a write cycle (CS_n and WR_n low, then WR_n rising while CS_n is still low) with `a0_ale_i` = 1 loads data bits [5:0] into the pointer, visible on `rf_addr_o`.
- R3: With `mode_i` = 2'b00, a write cycle with `a0_ale_i` = 0 stores the byte and produces exactly one single-cycle `rf_we_o` pulse, with `rf_addr_o` equal to the pointer and `rf_wdata_o` equal to the byte.
- R4: With `mode_i` = 2'b00, a read (CS_n and RD_n low) with `a0_ale_i` = 0 drives the read-data byte on `data_o`.
- R5: The read-data byte is reloaded from the register file location at the pointer after each pointer load, after each data read and after each data write; in the last case the reload returns the newly written value.
- R6: Data reads and writes never change the pointer, so repeated accesses target the same location.
- R7: With `mode_i` = 2'b00, a read with `a0_ale_i` = 1 drives 0x00 and changes neither the pointer nor the read-data byte.
- R8: With `mode_i` = 2'b01, the pointer is taken from data bits [5:0] while `a0_ale_i` is high, the read-data byte reloads when it falls, and the next RD_n or WR_n cycle reads or writes that location.
- R9: `data_oe_o` is high only while CS_n and RD_n are both low in mode 2'b00 or 2'b01.
- R10: With `mode_i` = 2'b10 or 2'b11, bus strobes cause no pointer change, no register file write and no bus drive.
- R11: Read and write strobes while CS_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Static bus mode: 00 direct, 01 multiplexed, 10/11 bus ignored |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| a0_ale_i | input | 1 | Window select in direct mode, address latch strobe in multiplexed mode |
| data_i | input | 8 | Bus data / address in |
| data_o | output | 8 | Bus read data |
| data_oe_o | output | 1 | Bus output enable |
| rf_addr_o | output | 6 | Register file location (the pointer) |
| rf_rdata_i | input | 8 | Register file read data at `rf_addr_o` |
| rf_we_o | output | 1 | Register file write pulse |
| rf_wdata_o | output | 8 | Register file write data |

## Verification
The hardest case to reach from the ports is a stale read-data byte during a burst. The byte is reloaded at the end of each read, so a read returns what the location held after the previous access, not what it holds now. The bench changes a register file location behind the block's back between two burst reads. It expects the first read to return the old value and the second to return the new one. It also checks that a reserved-slot read in between does not trigger a reload.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 6;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_MUXED  = 2'b01,
    MODE_SERIAL = 2'b10,
    MODE_RSVD   = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic          cs_n;
    logic          rd_n;
    logic          wr_n;
    logic          sel;
    logic [DW-1:0] data;
  } bus_s;

  localparam int unsigned BUS_W = $bits(bus_s);
endpackage

// File: rtl/rfp_sync.sv
module rfp_sync #(
  parameter int unsigned           WIDTH   = 12,
  parameter int unsigned           STAGES  = 2,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rfp_decode.sv
module rfp_decode
  import rfp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  bus_s          bus_i,
  output logic          ptr_load_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          data_wr_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          refresh_o
);
  bus_mode_e mode;
  logic p_cs_n, p_rd_n, p_wr_n, p_sel;
  logic [DW-1:0] hold_q;
  logic wr_rise, rd_rise, sel_fall, is_direct, is_muxed;

  assign mode      = bus_mode_e'(mode_i);
  assign is_direct = (mode == MODE_DIRECT);
  assign is_muxed  = (mode == MODE_MUXED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_cs_n <= 1'b1;
      p_rd_n <= 1'b1;
      p_wr_n <= 1'b1;
      p_sel  <= 1'b0;
      hold_q <= '0;
    end else begin
      p_cs_n <= bus_i.cs_n;
      p_rd_n <= bus_i.rd_n;
      p_wr_n <= bus_i.wr_n;
      p_sel  <= bus_i.sel;
      // last byte seen while a selected write strobe is low
      if (!bus_i.cs_n && !bus_i.wr_n) hold_q <= bus_i.data;
    end
  end

  assign wr_rise  = !p_wr_n && bus_i.wr_n && !p_cs_n;
  assign rd_rise  = !p_rd_n && bus_i.rd_n && !p_cs_n;
  assign sel_fall = p_sel && !bus_i.sel;

  always_comb begin
    ptr_load_o = 1'b0;
    ptr_val_o  = hold_q[AW-1:0];
    data_wr_o  = 1'b0;
    refresh_o  = 1'b0;
    if (is_direct) begin
      ptr_load_o = wr_rise && p_sel;
      data_wr_o  = wr_rise && !p_sel;
      refresh_o  = wr_rise || (rd_rise && !p_sel);
    end else if (is_muxed) begin
      ptr_load_o = bus_i.sel;
      ptr_val_o  = bus_i.data[AW-1:0];
      data_wr_o  = wr_rise;
      refresh_o  = sel_fall || wr_rise || rd_rise;
    end
  end

  assign wr_byte_o = hold_q;
endmodule

// File: rtl/rfp_regs.sv
module rfp_regs
  import rfp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_val_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wr_byte_i,
  input  logic          refresh_i,
  input  logic [DW-1:0] rf_rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] din_o,
  output logic          we_o,
  output logic [DW-1:0] dout_o
);
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] din_q, dout_q;
  logic          we_q, ref1_q, ref2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      din_q  <= '0;
      we_q   <= 1'b0;
      ref1_q <= 1'b0;
      ref2_q <= 1'b0;
      dout_q <= '0;
    end else begin
      if (ptr_load_i) ptr_q <= ptr_val_i;
      if (data_wr_i)  din_q <= wr_byte_i;
      we_q   <= data_wr_i;
      // two-cycle delay lets a write land before the reload samples it
      ref1_q <= refresh_i;
      ref2_q <= ref1_q;
      if (ref2_q) dout_q <= rf_rdata_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign din_o  = din_q;
  assign we_o   = we_q;
  assign dout_o = dout_q;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);  // R3
  AST_RELOAD_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> ref2_q); // R5
endmodule

// File: rtl/regfile_access_port.sv
module regfile_access_port
  import rfp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          a0_ale_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [AW-1:0] rf_addr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [DW-1:0] rf_wdata_o
);
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, 1'b0, {DW{1'b0}}};

  bus_s          raw_bus, s_bus;
  logic          ptr_load, data_wr, refresh;
  logic [AW-1:0] ptr_val;
  logic [DW-1:0] wr_byte, dout;
  logic          bus_live;

  assign raw_bus = '{cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni, sel: a0_ale_i, data: data_i};

  rfp_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_bus),
    .q_o    (s_bus)
  );

  rfp_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .bus_i      (s_bus),
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .data_wr_o  (data_wr),
    .wr_byte_o  (wr_byte),
    .refresh_o  (refresh)
  );

  rfp_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_load_i (ptr_load),
    .ptr_val_i  (ptr_val),
    .data_wr_i  (data_wr),
    .wr_byte_i  (wr_byte),
    .refresh_i  (refresh),
    .rf_rdata_i (rf_rdata_i),
    .ptr_o      (rf_addr_o),
    .din_o      (rf_wdata_o),
    .we_o       (rf_we_o),
    .dout_o     (dout)
  );

  assign bus_live  = (mode_i == MODE_DIRECT) || (mode_i == MODE_MUXED);
  assign data_oe_o = bus_live && !cs_ni && !rd_ni;
  // reserved slot in direct mode reads as zero
  assign data_o    = ((mode_i == MODE_DIRECT) && a0_ale_i) ? '0 : dout;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);              // R9
  AST_WE_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $stable(rf_addr_o));    // R6
endmodule

// File: tb/regfile_access_port_tb_top.sv
module regfile_access_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, rf_rdata, rf_wdata;
  logic       oe, rf_we;
  logic [5:0] rf_addr;

  logic [7:0] rf_mem  [64];
  logic [7:0] exp_mem [64];
  logic [5:0] m_ptr;
  logic [7:0] m_dout;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [13:0] wr_q [$];  // {addr, data}
  logic [8:0]  rd_q [$];  // {oe, data}
  string       rd_tag_q [$];
  event        ev_rd;

  always #5 clk = ~clk;

  regfile_access_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .a0_ale_i(a0), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata)
  );

  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // write monitor
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (wr_q.size() == 0) chk(1'b0, "R10/R11 unexpected write", {rf_addr, rf_wdata}, 0);
      else begin
        logic [13:0] e;
        e = wr_q.pop_front();
        chk({rf_addr, rf_wdata} == e, "R3 write addr/data", {rf_addr, rf_wdata}, e);
      end
    end
  end

  // read monitor
  initial forever begin
    @(ev_rd);
    begin
      logic [8:0] e;
      string t;
      e = rd_q.pop_front();
      t = rd_tag_q.pop_front();
      if (e[8]) chk(oe && dout == e[7:0], t, {oe, dout}, e);
      else      chk(!oe, t, {oe, dout}, e);
    end
  end

  task automatic bus_wr(input logic sel, input logic [7:0] d, input logic cs_val);
    @(negedge clk);
    a0 = sel; din = d; cs_n = cs_val;
    @(negedge clk); wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; a0 = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_rd(input logic sel, input logic cs_val, input logic exp_oe,
                        input logic [7:0] exp_d, input string tag);
    @(negedge clk);
    a0 = sel; cs_n = cs_val;
    @(negedge clk); rd_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_q.push_back({exp_oe, exp_d});
    rd_tag_q.push_back(tag);
    -> ev_rd;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; a0 = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic ptr_wr(input logic [5:0] p);
    bus_wr(1'b1, {2'b00, p}, 1'b0);
    m_ptr = p; m_dout = exp_mem[p];
  endtask

  task automatic data_wr(input logic [7:0] d);
    wr_q.push_back({m_ptr, d});
    exp_mem[m_ptr] = d;
    bus_wr(1'b0, d, 1'b0);
    m_dout = exp_mem[m_ptr];
  endtask

  task automatic data_rd(input string tag);
    bus_rd(1'b0, 1'b0, 1'b1, m_dout, tag);
    m_dout = exp_mem[m_ptr];
  endtask

  task automatic ale_latch(input logic [5:0] p);
    @(negedge clk); a0 = 1'b1; din = {2'b11, p};
    repeat (3) @(negedge clk);
    a0 = 1'b0;
    repeat (8) @(negedge clk);
    m_ptr = p; m_dout = exp_mem[p];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      rf_mem[i]  = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    m_ptr = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rf_addr == 0 && rf_wdata == 0 && !rf_we && !oe, "R1 reset", {rf_addr, rf_wdata}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 pointer load, R4/R5 read after pointer write
    ptr_wr(6'd5);
    chk(rf_addr == 6'd5, "R2 pointer load", rf_addr, 5);
    data_rd("R4 R5 read after pointer load");

    // R3 data write, R5 reload after write, R6 pointer kept
    data_wr(8'hA5);
    chk(rf_addr == 6'd5, "R6 pointer unchanged by write", rf_addr, 5);
    data_rd("R5 read after write");

    // burst with location changed behind the block
    rf_mem[5] = 8'h3C; exp_mem[5] = 8'h3C;
    data_rd("R5 stale byte before reload");
    // R7 reserved slot: zero, no reload
    rf_mem[5] = 8'h4D; exp_mem[5] = 8'h4D;
    bus_rd(1'b1, 1'b0, 1'b1, 8'h00, "R7 reserved read zero");
    data_rd("R7 R5 reserved read caused no reload");
    data_rd("R6 burst read same location");
    data_wr(8'h11);
    data_wr(8'h22);
    chk(rf_addr == 6'd5, "R6 pointer after burst writes", rf_addr, 5);
    data_rd("R6 burst read after writes");

    // R11 CS_n high
    bus_wr(1'b1, 8'h09, 1'b1);
    bus_wr(1'b0, 8'hEE, 1'b1);
    chk(rf_addr == 6'd5, "R11 pointer ignores deselected write", rf_addr, 5);
    bus_rd(1'b0, 1'b1, 1'b0, 8'h00, "R9 R11 no drive when deselected");
    data_rd("R11 data byte kept");

    // R9 CS_n low, RD_n high
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!oe, "R9 no drive without RD_n", oe, 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 multiplexed mode
    mode = 2'b01;
    repeat (4) @(negedge clk);
    ale_latch(6'h2A);
    chk(rf_addr == 6'h2A, "R8 address latched", rf_addr, 8'h2A);
    data_rd("R8 muxed read");
    data_wr(8'h77);
    data_rd("R8 R5 muxed read after write");
    ale_latch(6'h3F);
    data_rd("R8 muxed read top location");

    // R10 serial and reserved codes
    for (int m = 2; m < 4; m++) begin
      mode = 2'(m);
      repeat (4) @(negedge clk);
      bus_wr(1'b1, 8'h03, 1'b0);
      bus_wr(1'b0, 8'h99, 1'b0);
      chk(rf_addr == 6'h3F, "R10 pointer unchanged", rf_addr, 8'h3F);
      bus_rd(1'b0, 1'b0, 1'b0, 8'h00, "R10 no drive");
    end
    mode = 2'b00;
    repeat (4) @(negedge clk);
    data_rd("R10 data byte kept");

    repeat (10) @(negedge clk);
    chk(wr_q.size() == 0, "R3 all expected writes seen", wr_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule